// File: doc/BRIEF.md
# Gated LFSR Signature Analyzer

This block compresses a serial bit stream into a 16-bit signature. Four external lines (measurement clock, start qualifier, stop qualifier and serial data) pass through a two-flop synchronizer into the system clock domain. The block reacts only to the active edge of the measurement clock. On that edge it samples the qualifiers and the data bit.

A measurement window opens when the start line moves to its active level. It closes when the stop line moves to its active level. While the window is open, every sampled data bit is folded into a right-shifting feedback register. When the window closes, the register contents appear on the signature output with a single-cycle valid pulse. A four-character ASCII display code is also formed, which a front panel can show.

Each of the three edge polarities is chosen by its own configuration input. Configuration is expected to change only around a reset.

Top module: `sig_analyzer`

## Requirements
- R1: The block samples start, stop and data only on the active edge of the measurement clock. The active edge is falling when `cfg_clk_rise` is 0 and rising when it is 1. Level changes on the qualifiers that are undone before the next active edge have no effect.
- R2: While the window is closed, it opens on an active edge where the start line differs from its value at the previous active edge and now equals the active level. The active level is 1 when `cfg_start_rise` is 1 and 0 when it is 0.
- R3: While the window is open, it closes on an active edge where the stop line differs from its previous sampled value and now equals the active level. The active level is 1 when `cfg_stop_rise` is 1 and 0 when it is 0.
- R4: During reset, the previous-value trackers for start and stop are set to the inactive level of their polarity. A start line already held at its active level through reset therefore opens the window on the first active edge.
- R5: On each in-window edge that neither opens nor closes the window, the register shifts right by one. Bit 15 takes the XOR of register bits 0, 4, 7 and 9 with the data bit.
- R6: The register clears on the opening edge, and the data bit of that edge is shifted in. The data bit of the closing edge is not shifted in.
- R7: On the closing edge, `signature` takes the register value and `sig_valid` is high for exactly one cycle. `signature` then holds until the next close.
- R8: `disp_code[8k+7:8k]` is the ASCII character for `signature[4k+3:4k]`, for k = 0 to 3. Nibble values 0 to 15 map to the characters 0-9, A, C, F, H, P, U.
- R9: The synchronous active-high `rst` closes the window and clears the register, `signature` and `sig_valid`.
- R10: A start transition while the window is open has no effect. A stop transition while the window is closed has no effect.
- R11: `sig_valid` rises after the third system clock edge that follows the active measurement clock transition on the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_clk_rise | input | 1 | 1: rising measurement clock edge is active; 0: falling |
| cfg_start_rise | input | 1 | 1: start is active high; 0: active low |
| cfg_stop_rise | input | 1 | 1: stop is active high; 0: active low |
| meas_clk_in | input | 1 | Measurement clock line |
| start_in | input | 1 | Start qualifier line |
| stop_in | input | 1 | Stop qualifier line |
| data_in | input | 1 | Serial data line |
| sig_valid | output | 1 | One-cycle pulse when a window closes |
| signature | output | 16 | Last captured signature |
| disp_code | output | 32 | Four ASCII characters, lowest nibble in bits 7:0 |

## Verification
The window state and the feedback register are never visible at the ports. A fault in either one shows up only when the next window closes. At that point it appears as a wrong signature value, a missing or extra valid pulse, or a pulse in the wrong cycle. Comparing against a cycle-level model on every clock catches such a fault in the very cycle the close should or should not have happened. It also catches any mismatch in the display characters as soon as the signature changes.

// File: rtl/sig_analyzer.sv
module sig_analyzer #(
  parameter int SIG_W = 16,
  parameter logic [SIG_W-1:0] TAP_MASK = 16'h0291,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_clk_rise,
  input  logic               cfg_start_rise,
  input  logic               cfg_stop_rise,
  input  logic               meas_clk_in,
  input  logic               start_in,
  input  logic               stop_in,
  input  logic               data_in,
  output logic               sig_valid,
  output logic [SIG_W-1:0]   signature,
  output logic [2*SIG_W-1:0] disp_code
);
  localparam int NCHAR = SIG_W / 4;

  logic [SYNC_STAGES-1:0][3:0] sync_q;
  logic [3:0] smp;
  logic mclk_prev, start_prev, stop_prev, win_open;
  logic [SIG_W-1:0] shreg;
  logic mclk_act, start_hit, stop_hit, open_evt, close_evt, shift_evt, fb;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], {meas_clk_in, start_in, stop_in, data_in}};
  end

  assign smp       = sync_q[SYNC_STAGES-1];
  assign mclk_act  = (smp[3] != mclk_prev) && (smp[3] == cfg_clk_rise);
  assign start_hit = (smp[2] != start_prev) && (smp[2] == cfg_start_rise);
  assign stop_hit  = (smp[1] != stop_prev) && (smp[1] == cfg_stop_rise);
  assign open_evt  = mclk_act && !win_open && start_hit;
  assign close_evt = mclk_act && win_open && stop_hit;
  assign shift_evt = mclk_act && win_open && !stop_hit;
  assign fb        = ^(shreg & TAP_MASK) ^ smp[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mclk_prev  <= 1'b0;
      start_prev <= !cfg_start_rise;
      stop_prev  <= !cfg_stop_rise;
      win_open   <= 1'b0;
      shreg      <= '0;
      signature  <= '0;
      sig_valid  <= 1'b0;
    end else begin
      mclk_prev <= smp[3];
      sig_valid <= close_evt;
      if (mclk_act) begin
        start_prev <= smp[2];
        stop_prev  <= smp[1];
      end
      if (open_evt) begin
        win_open <= 1'b1;
        shreg    <= {smp[0], {(SIG_W-1){1'b0}}};
      end else if (close_evt) begin
        win_open  <= 1'b0;
        signature <= shreg;
      end else if (shift_evt) begin
        shreg <= {fb, shreg[SIG_W-1:1]};
      end
    end
  end

  function automatic logic [7:0] glyph(input logic [3:0] n);
    case (n)
      4'd10:   glyph = 8'h41;
      4'd11:   glyph = 8'h43;
      4'd12:   glyph = 8'h46;
      4'd13:   glyph = 8'h48;
      4'd14:   glyph = 8'h50;
      4'd15:   glyph = 8'h55;
      default: glyph = 8'h30 + {4'h0, n};
    endcase
  endfunction

  for (genvar c = 0; c < NCHAR; c++) begin : g_char
    assign disp_code[8*c +: 8] = glyph(signature[4*c +: 4]);
  end
endmodule

// File: rtl/sig_analyzer_chk.sv
module sig_analyzer_chk #(
  parameter int SIG_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             win_open,
  input logic [SIG_W-1:0] shreg,
  input logic             sig_valid,
  input logic [SIG_W-1:0] signature
);
  a_r7_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
    sig_valid |=> !sig_valid);

  a_r7_sig_hold: assert property (@(posedge clk) disable iff (rst)
    (!sig_valid && !$past(rst)) |-> $stable(signature));

  a_r7_sig_from_reg: assert property (@(posedge clk) disable iff (rst)
    (sig_valid && !$past(rst)) |-> (signature == $past(shreg)));

  a_r6_clear_on_open: assert property (@(posedge clk) disable iff (rst)
    $rose(win_open) |-> (shreg[SIG_W-2:0] == '0));

  a_r3_close_gives_valid: assert property (@(posedge clk) disable iff (rst)
    ($fell(win_open) && !$past(rst)) |-> sig_valid);

  a_r5_shift_right: assert property (@(posedge clk) disable iff (rst)
    (win_open && $past(win_open) && !$past(rst) && !$stable(shreg))
      |-> (shreg[SIG_W-2:0] == $past(shreg[SIG_W-1:1])));

  a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sig_valid && signature == '0 && !win_open));
endmodule

bind sig_analyzer sig_analyzer_chk #(.SIG_W(SIG_W)) chk_i (
  .clk(clk), .rst(rst), .win_open(win_open), .shreg(shreg),
  .sig_valid(sig_valid), .signature(signature)
);

// File: tb/sig_analyzer_tb_top.sv
module sig_analyzer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_clk_rise = 1'b0, cfg_start_rise = 1'b1, cfg_stop_rise = 1'b1;
  logic mclk = 1'b0, st = 1'b0, sp = 1'b0, dt = 1'b0;
  logic sig_valid;
  logic [15:0] signature;
  logic [31:0] disp_code;

  int total = 0, bad = 0, vcount = 0;
  bit cmp_on = 0, done = 0;
  int unsigned lcg = 32'h1234_5678;
  string alpha = "0123456789ACFHPU";

  always #2.5 clk = ~clk;

  sig_analyzer dut_i (
    .clk(clk), .rst(rst), .cfg_clk_rise(cfg_clk_rise),
    .cfg_start_rise(cfg_start_rise), .cfg_stop_rise(cfg_stop_rise),
    .meas_clk_in(mclk), .start_in(st), .stop_in(sp), .data_in(dt),
    .sig_valid(sig_valid), .signature(signature), .disp_code(disp_code)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int step(input int sr, input bit d);
    int taps[4] = '{0, 4, 7, 9};
    bit p = d;
    foreach (taps[i]) p ^= sr[taps[i]];
    return (int'(p) << 15) | (sr >> 1);
  endfunction

  function automatic logic [31:0] disp_of(input int s);
    logic [31:0] r;
    for (int c = 0; c < 4; c++) r[8*c +: 8] = alpha[(s >> (4*c)) & 15];
    return r;
  endfunction

  // behavioural reference model
  logic [3:0] pipe[$];
  logic [3:0] cur;
  bit m_mprev, m_sprev, m_pprev, m_open, m_val, s_hit, p_hit;
  int m_sr, m_sig;

  always @(posedge clk) begin
    if (rst) begin
      pipe = '{4'h0, 4'h0};
      m_mprev = 0; m_open = 0; m_sr = 0; m_sig = 0; m_val = 0;
      m_sprev = !cfg_start_rise; m_pprev = !cfg_stop_rise;
    end else begin
      cur = pipe.pop_front();
      pipe.push_back({mclk, st, sp, dt});
      m_val = 0;
      if (cur[3] != m_mprev && cur[3] == cfg_clk_rise) begin
        s_hit = (cur[2] != m_sprev) && (cur[2] == cfg_start_rise);
        p_hit = (cur[1] != m_pprev) && (cur[1] == cfg_stop_rise);
        if (!m_open && s_hit) begin m_open = 1; m_sr = cur[0] ? 32'h8000 : 0; end
        else if (m_open && p_hit) begin m_open = 0; m_sig = m_sr; m_val = 1; end
        else if (m_open) m_sr = step(m_sr, cur[0]);
        m_sprev = cur[2]; m_pprev = cur[1];
      end
      m_mprev = cur[3];
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk("R7 per-cycle valid/signature", {15'h0, sig_valid, signature}, {15'h0, m_val, m_sig[15:0]});
      chk("R8 per-cycle display", disp_code, disp_of(m_sig));
      if (sig_valid) vcount++;
    end
  end

  task automatic tick(input bit s, input bit p, input bit d);
    @(negedge clk); st = s; sp = p; dt = d;
    repeat (4) @(negedge clk); mclk = 1'b1;
    repeat (4) @(negedge clk); mclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (5) @(negedge clk); rst = 1'b0;
  endtask

  function automatic bit rbit();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg[20];
  endfunction

  // full window: open, n-1 more bits, close; optional start toggle inside
  task automatic window(input int n, input bit toggle_start, input string req);
    bit as = cfg_start_rise, ap = cfg_stop_rise, b;
    int exp = 0, v0 = vcount;
    for (int i = 0; i < n; i++) begin
      b = rbit();
      exp = (i == 0) ? (b ? 32'h8000 : 0) : step(exp, b);
      tick((toggle_start && i == n/2) ? !as : as, !ap, b);
    end
    tick(as, ap, rbit());
    tick(!as, !ap, 1'b0);
    chk({req, " signature"}, {16'h0, signature}, exp);
    chk({req, " one valid pulse"}, vcount - v0, 1);
  endtask

  initial begin
    int v0;
    do_reset();
    cmp_on = 1;
    chk("R9 reset valid", {31'h0, sig_valid}, 0);
    chk("R9 reset signature", {16'h0, signature}, 0);
    chk("R8 reset display", disp_code, 32'h3030_3030);

    // R10: stop toggles while closed
    v0 = vcount;
    tick(0, 1, 1); tick(0, 0, 0);
    chk("R10 stop while closed ignored", vcount - v0, 0);

    window(20, 0, "R2 R3 R5 R6 default polarity");
    window(33, 1, "R10 start toggle in window");

    // R1: start pulse between active edges
    v0 = vcount;
    @(negedge clk); st = 1; repeat (4) @(negedge clk); mclk = 1;
    repeat (4) @(negedge clk); st = 0; repeat (4) @(negedge clk); mclk = 0;
    repeat (4) @(negedge clk);
    tick(0, 1, 0); tick(0, 0, 0);
    chk("R1 inactive-edge start ignored", vcount - v0, 0);
    chk("R7 signature holds", {16'h0, signature}, m_sig);

    // R11: latency of valid
    tick(1, 0, 1); tick(1, 0, 0);
    @(negedge clk); sp = 1; repeat (4) @(negedge clk); mclk = 1;
    repeat (4) @(negedge clk); mclk = 0;
    @(negedge clk); @(negedge clk);
    chk("R11 valid low after 2 edges", {31'h0, sig_valid}, 0);
    @(negedge clk);
    chk("R11 valid high after 3 edges", {31'h0, sig_valid}, 1);
    @(negedge clk);
    chk("R11 valid one cycle", {31'h0, sig_valid}, 0);
    tick(0, 0, 0);

    // R1 R2 R3: rising clock, active-low qualifiers
    cfg_clk_rise = 1; cfg_start_rise = 0; cfg_stop_rise = 0;
    st = 1; sp = 1;
    do_reset();
    chk("R9 reset clears signature", {16'h0, signature}, 0);
    window(25, 0, "R1 R2 R3 rising clock low qualifiers");

    // R4: start held active through reset
    cfg_clk_rise = 0; cfg_start_rise = 1; cfg_stop_rise = 1;
    st = 1; sp = 0;
    do_reset();
    window(12, 0, "R4 start active through reset");

    // R9: reset mid-window
    tick(1, 0, 1); tick(1, 0, 1); tick(1, 0, 0);
    st = 0; sp = 0;
    do_reset();
    chk("R9 mid-window reset signature", {16'h0, signature}, 0);
    v0 = vcount;
    tick(0, 1, 0); tick(0, 0, 0);
    chk("R9 window closed after reset", vcount - v0, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule